// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into a stream of column addresses, one per clock. A load strobe registers a start column together with the burst shape: a length code, an ordering choice (wrapping linear or XOR-scrambled) and a flag asking that writes touch a single column. From the next cycle the block presents the column of each beat, marks the beat that closes the burst and steps on to the next column on every clock in which its clock-enable is high.

A burst can end in three ways. It runs out at its programmed length. A stop input cuts it short. A fresh load abandons it and starts over from the new column. The full-row code keeps cycling through all columns of the row and only ends on stop or load. Length codes that have no meaning fall back to a single beat and set a sticky error flag, which only reset clears.

Top module: `colburst_gen`

## Requirements
- R1: While reset is held, and immediately after it, beat_valid, beat_last and cfg_err are all 0.
- R2: A load sampled with cke high makes beat_valid 1 and col_out equal to load_col on the following cycle. Each later clock with cke high advances the burst by one beat.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give 1, 2, 4 and 8 beats. beat_last is 1 on the final beat only, and beat_valid is 0 on the cycle after that beat.
- R4: With mode_ilv = 0, beat k shows column ((start + k) mod L) in the low log2(L) bits, and the bits above them stay equal to the start column. For example, L = 4 from column 1 gives 1, 2, 3, 0, and L = 8 from 0x45 gives 0x45, 0x46, 0x47, 0x40 and on to 0x44.
- R5: With mode_ilv = 1, beat k shows start XOR k. For example, L = 8 from 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R6: Code 3'b111 with mode_ilv = 0 is a full-row burst. It increments modulo 2^COL_W (0xFF is followed by 0x00), never raises beat_last, and continues until stop or load.
- R7: Codes 3'b100, 3'b101 and 3'b110, and code 3'b111 with mode_ilv = 1, produce a one-beat burst at load_col and set cfg_err. cfg_err then stays 1 until reset.
- R8: A load with load_write = 1 and mode_single = 1 produces a one-beat burst, whatever the length code. Reads with mode_single = 1, and writes with mode_single = 0, use the full length.
- R9: A stop sampled with cke high and no load makes beat_valid 0 on the next cycle.
- R10: A load arriving during a burst, including on its last beat or together with stop, restarts from the new column on the next cycle. Load wins over stop.
- R11: While cke is low, col_out, beat_valid and the beat position hold their values, and load and stop are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Advance enable; low suspends the block |
| load | input | 1 | Start a new burst |
| load_col | input | COL_W | Start column |
| load_write | input | 1 | The burst is a write |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 selects XOR order, 0 selects wrapping linear order |
| mode_single | input | 1 | Writes use a single column |
| stop | input | 1 | Terminate the current burst |
| col_out | output | COL_W | Column of the current beat |
| beat_valid | output | 1 | col_out holds a burst beat |
| beat_last | output | 1 | Current beat is the final one |
| cfg_err | output | 1 | Sticky flag for an unsupported length code |

## Verification
Several functions can land in the same cycle. The cases exercised here are a load coinciding with a stop, a load arriving on the final beat of a running burst, and load or stop applied while cke is low. Each is provoked by driving both inputs on one negative edge. The bench judges the result against a behavioural queue model that is consulted every clock: load must win over stop, a new burst must follow the last beat with no idle cycle between them, and a suspended cycle must change nothing. Directed checks with literal column values sit beside the model for the wrap, XOR and row-rollover orders.

// File: rtl/colburst_pkg.sv
package colburst_pkg;
   localparam int FIX_LOG2_MAX = 3;

   typedef enum logic [2:0] {
      BL_ONE   = 3'd0,
      BL_TWO   = 3'd1,
      BL_FOUR  = 3'd2,
      BL_EIGHT = 3'd3,
      BL_PAGE  = 3'd7
   } blen_e;
endpackage

// File: rtl/colburst_mode.sv
module colburst_mode
   import colburst_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [2:0]       len_code,
   input  logic             ilv,
   input  logic             is_write,
   input  logic             single_wr,
   output logic [COL_W-1:0] mask,
   output logic             full,
   output logic             bad
);
   logic [COL_W-1:0] fixed_mask;
   logic             is_fixed;
   logic             is_page;
   logic             shortened;

   if (COL_W < FIX_LOG2_MAX) begin : g_width_check
      $error("colburst_mode: COL_W must cover an eight-beat block");
   end

   for (genvar i = 0; i < COL_W; i++) begin : g_fix
      assign fixed_mask[i] = (int'(len_code[1:0]) > i);
   end

   always_comb begin
      is_fixed  = (len_code[2] == 1'b0);
      is_page   = (len_code == BL_PAGE) && !ilv;
      bad       = !is_fixed && !is_page;
      shortened = bad || (is_write && single_wr);
      full      = is_page && !shortened;
      if (shortened)    mask = '0;
      else if (is_page) mask = '1;
      else              mask = fixed_mask;
   end
endmodule

// File: rtl/colburst_seq.sv
module colburst_seq #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             load,
   input  logic             stop,
   input  logic [COL_W-1:0] load_col,
   input  logic [COL_W-1:0] load_mask,
   input  logic             load_full,
   input  logic             load_ilv,
   output logic             busy,
   output logic [COL_W-1:0] beat,
   output logic [COL_W-1:0] start_q,
   output logic [COL_W-1:0] mask_q,
   output logic             full_q,
   output logic             ilv_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         beat    <= '0;
         start_q <= '0;
         mask_q  <= '0;
         full_q  <= 1'b0;
         ilv_q   <= 1'b0;
      end else if (cke) begin
         if (load) begin
            busy    <= 1'b1;
            beat    <= '0;
            start_q <= load_col;
            mask_q  <= load_mask;
            full_q  <= load_full;
            ilv_q   <= load_ilv;
         end else if (stop) begin
            busy <= 1'b0;
         end else if (busy) begin
            if (!full_q && (beat == mask_q)) busy <= 1'b0;
            else                             beat <= beat + 1'b1;
         end
      end
   end

   assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && stop && !load) |=> !busy);

   assert_load_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && load) |=> (busy && (beat == '0) && (start_q == $past(load_col))));

   assert_suspend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ($stable(beat) && $stable(busy) && $stable(start_q)));
endmodule

// File: rtl/colburst_addr.sv
module colburst_addr #(
   parameter int COL_W = 8
) (
   input  logic [COL_W-1:0] start,
   input  logic [COL_W-1:0] beat,
   input  logic [COL_W-1:0] mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] lin;
   logic [COL_W-1:0] mix;

   assign lin = start + beat;
   assign mix = start ^ beat;

   for (genvar i = 0; i < COL_W; i++) begin : g_bit
      assign col[i] = mask[i] ? (ilv ? mix[i] : lin[i]) : start[i];
   end
endmodule

// File: rtl/colburst_gen.sv
module colburst_gen #(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             load,
   input  logic [COL_W-1:0] load_col,
   input  logic             load_write,
   input  logic [2:0]       mode_len,
   input  logic             mode_ilv,
   input  logic             mode_single,
   input  logic             stop,
   output logic [COL_W-1:0] col_out,
   output logic             beat_valid,
   output logic             beat_last,
   output logic             cfg_err
);
   logic [COL_W-1:0] new_mask;
   logic             new_full;
   logic             new_bad;
   logic             busy;
   logic [COL_W-1:0] beat;
   logic [COL_W-1:0] start_q;
   logic [COL_W-1:0] mask_q;
   logic             full_q;
   logic             ilv_q;

   colburst_mode #(.COL_W(COL_W)) u_mode (
      .len_code (mode_len),
      .ilv      (mode_ilv),
      .is_write (load_write),
      .single_wr(mode_single),
      .mask     (new_mask),
      .full     (new_full),
      .bad      (new_bad)
   );

   colburst_seq #(.COL_W(COL_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cke      (cke),
      .load     (load),
      .stop     (stop),
      .load_col (load_col),
      .load_mask(new_mask),
      .load_full(new_full),
      .load_ilv (mode_ilv),
      .busy     (busy),
      .beat     (beat),
      .start_q  (start_q),
      .mask_q   (mask_q),
      .full_q   (full_q),
      .ilv_q    (ilv_q)
   );

   colburst_addr #(.COL_W(COL_W)) u_addr (
      .start(start_q),
      .beat (beat),
      .mask (mask_q),
      .ilv  (ilv_q),
      .col  (col_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cfg_err <= 1'b0;
      else if (cke && load && new_bad)  cfg_err <= 1'b1;
   end

   assign beat_valid = busy;
   assign beat_last  = busy && !full_q && (beat == mask_q);

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);

   assert_last_then_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && beat_last && !load) |=> !beat_valid);

   assert_col_hi_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cke && beat_valid && !load) |=> (((col_out ^ $past(col_out)) & ~mask_q) == '0));
endmodule

// File: tb/tb_colburst_gen.sv
`timescale 1ns/1ps
module tb_colburst_gen;
   localparam int COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             cke;
   logic             load;
   logic [COL_W-1:0] load_col;
   logic             load_write;
   logic [2:0]       mode_len;
   logic             mode_ilv;
   logic             mode_single;
   logic             stop;
   logic [COL_W-1:0] col_out;
   logic             beat_valid;
   logic             beat_last;
   logic             cfg_err;

   int    checks = 0;
   int    errs   = 0;
   string cur    = "R1";

   int q[$];
   bit m_full = 1'b0;
   bit m_err  = 1'b0;

   always #10 clk = ~clk;

   colburst_gen #(.COL_W(COL_W)) dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .load(load), .load_col(load_col),
      .load_write(load_write), .mode_len(mode_len), .mode_ilv(mode_ilv),
      .mode_single(mode_single), .stop(stop), .col_out(col_out),
      .beat_valid(beat_valid), .beat_last(beat_last), .cfg_err(cfg_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic void build(int s, int code, bit il, bit wr, bit sg);
      int len;
      int m;
      q.delete();
      m_full = 1'b0;
      if (code <= 3) len = 1 << code;
      else if (code == 7 && !il) begin len = 256; m_full = 1'b1; end
      else begin len = 1; m_err = 1'b1; end
      if (wr && sg) begin len = 1; m_full = 1'b0; end
      m = len - 1;
      for (int i = 0; i < len; i++) begin
         if (il) q.push_back((s ^ i) & 255);
         else    q.push_back((s & ~m & 255) | ((s + i) & m));
      end
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         m_full = 1'b0;
         m_err  = 1'b0;
      end else if (cke) begin
         if (load) build(int'(load_col), int'(mode_len), mode_ilv, load_write, mode_single);
         else if (stop) q.delete();
         else if (q.size() > 0) begin
            int h;
            h = q.pop_front();
            if (m_full) q.push_back(h);
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk({cur, " model valid"}, int'(beat_valid), int'(q.size() > 0));
         chk({cur, " model last"}, int'(beat_last), int'(q.size() == 1 && !m_full));
         chk({cur, " model err"}, int'(cfg_err), int'(m_err));
         if (q.size() > 0) chk({cur, " model col"}, int'(col_out), q[0]);
      end
   end

   task automatic issue(input int c, input int code, input bit il, input bit wr, input bit sg);
      load = 1'b1; load_col = c[7:0]; mode_len = code[2:0];
      mode_ilv = il; load_write = wr; mode_single = sg;
      @(negedge clk);
      load = 1'b0;
   endtask

   initial begin
      int seq5 [8] = '{5, 4, 7, 6, 1, 0, 3, 2};
      bit saw_last;
      rst_n = 1'b0; cke = 1'b1; load = 1'b0; load_col = '0; load_write = 1'b0;
      mode_len = '0; mode_ilv = 1'b0; mode_single = 1'b0; stop = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", int'(beat_valid), 0);
      chk("R1 last in reset", int'(beat_last), 0);
      chk("R1 err in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", int'(beat_valid), 0);

      cur = "R4";
      issue(1, 2, 0, 0, 0);
      chk("R2 first col", int'(col_out), 1);
      chk("R2 valid", int'(beat_valid), 1);
      @(negedge clk); chk("R4 len4 beat1", int'(col_out), 2);
      @(negedge clk); chk("R4 len4 beat2", int'(col_out), 3);
      @(negedge clk); chk("R4 len4 wrap", int'(col_out), 0);
      chk("R3 last on beat 4", int'(beat_last), 1);
      @(negedge clk); chk("R3 idle after last", int'(beat_valid), 0);

      issue('h45, 3, 0, 0, 0);
      chk("R4 len8 start", int'(col_out), 'h45);
      repeat (3) @(negedge clk);
      chk("R4 len8 wrap high bits kept", int'(col_out), 'h40);
      repeat (4) @(negedge clk);
      chk("R4 len8 final col", int'(col_out), 'h44);
      chk("R3 len8 last", int'(beat_last), 1);
      @(negedge clk);

      cur = "R5";
      issue(5, 3, 1, 0, 0);
      for (int i = 0; i < 8; i++) begin
         chk("R5 xor order", int'(col_out), seq5[i]);
         if (i < 7) @(negedge clk);
      end
      chk("R5 last", int'(beat_last), 1);
      @(negedge clk);

      cur = "R3";
      issue(9, 0, 0, 0, 0);
      chk("R3 len1 col", int'(col_out), 9);
      chk("R3 len1 last", int'(beat_last), 1);
      @(negedge clk); chk("R3 len1 ends", int'(beat_valid), 0);
      issue(7, 1, 0, 0, 0);
      chk("R3 len2 first", int'(col_out), 7);
      chk("R3 len2 not last", int'(beat_last), 0);
      @(negedge clk); chk("R3 len2 wrap", int'(col_out), 6);
      @(negedge clk);

      cur = "R6";
      issue('hFE, 7, 0, 0, 0);
      chk("R6 page start", int'(col_out), 'hFE);
      @(negedge clk); chk("R6 page FF", int'(col_out), 'hFF);
      @(negedge clk); chk("R6 page rollover", int'(col_out), 0);
      saw_last = 1'b0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (beat_last) saw_last = 1'b1;
      end
      chk("R6 page never last", int'(saw_last), 0);
      chk("R6 page still running", int'(beat_valid), 1);
      cur = "R9";
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      chk("R9 stop ends page", int'(beat_valid), 0);

      cur = "R7";
      chk("R7 err clear before", int'(cfg_err), 0);
      issue('h30, 5, 0, 0, 0);
      chk("R7 reserved col", int'(col_out), 'h30);
      chk("R7 reserved one beat", int'(beat_last), 1);
      chk("R7 err set", int'(cfg_err), 1);
      issue('h31, 7, 1, 0, 0);
      chk("R7 page+xor one beat", int'(beat_last), 1);
      issue('h50, 2, 0, 0, 0);
      chk("R7 err sticky", int'(cfg_err), 1);
      repeat (4) @(negedge clk);

      cur = "R8";
      issue('h12, 3, 0, 1, 1);
      chk("R8 single write col", int'(col_out), 'h12);
      chk("R8 single write last", int'(beat_last), 1);
      @(negedge clk); chk("R8 single write ends", int'(beat_valid), 0);
      issue('h12, 3, 0, 0, 1);
      repeat (7) @(negedge clk);
      chk("R8 read keeps length", int'(col_out), 'h11);
      chk("R8 read last", int'(beat_last), 1);
      @(negedge clk);
      issue('h12, 3, 0, 1, 0);
      @(negedge clk);
      chk("R8 burst write continues", int'(col_out), 'h13);
      repeat (7) @(negedge clk);

      cur = "R9";
      issue('h20, 3, 0, 0, 0);
      @(negedge clk);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      chk("R9 stop mid burst", int'(beat_valid), 0);

      cur = "R10";
      issue('h40, 3, 0, 0, 0);
      @(negedge clk);
      issue('h80, 2, 0, 0, 0);
      chk("R10 reload mid burst", int'(col_out), 'h80);
      stop = 1'b1;
      issue('h90, 1, 0, 0, 0);
      stop = 1'b0;
      chk("R10 load beats stop", int'(col_out), 'h90);
      chk("R10 load beats stop valid", int'(beat_valid), 1);
      issue('hA0, 0, 0, 0, 0);
      chk("R10 single beat last", int'(beat_last), 1);
      issue('hB3, 2, 0, 0, 0);
      chk("R10 load on last beat", int'(col_out), 'hB3);
      chk("R10 no gap", int'(beat_valid), 1);
      repeat (4) @(negedge clk);

      cur = "R11";
      issue('h60, 2, 0, 0, 0);
      cke = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 hold col", int'(col_out), 'h60);
      load = 1'b1; load_col = 8'h77; stop = 1'b1;
      repeat (3) @(negedge clk);
      chk("R11 load and stop ignored", int'(col_out), 'h60);
      chk("R11 still valid", int'(beat_valid), 1);
      load = 1'b0; stop = 1'b0; cke = 1'b1;
      @(negedge clk);
      chk("R11 resume advances", int'(col_out), 'h61);
      repeat (4) @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule